// File: doc/BRIEF.md
# Serial Flash Page-Program Write Buffer

This block holds one 128-byte page for a serial NOR flash controller and sends it to the flash in a single program transaction. A role bit moves the shared on-chip buffer between read-prefetch duty and program duty. The new role shows on a readback output only after a fixed settling delay, so software writes the bit and polls until the readback agrees. In program role, software loads the page as 32 words of 32 bits through one data port. Each word is unpacked little-endian, so the lowest-addressed byte comes from bits 7:0.

A page command (code 0x10) then drops chip select and shifts out the page-program opcode, the address and all 128 bytes in one frame. A single-byte command (code 0x90) sends the same header followed by one byte taken from a write-data input. Software uses it for tail bytes after the buffer has gone back to prefetch role. A busy output plays the part of the command bit: it stays high until the frame has finished.

Top module: `nor_pp_wbuf`

## Requirements
- R1: While reset is applied and just after it: busy is 0, flash_cs_n is 1, flash_sck is 0, role_rd is 0 (prefetch role) and page_err is 0.
- R2: A write of role_val through role_set reaches role_rd exactly SETTLE_CYC clocks later, provided the block is idle and no command starts during those clocks. While a frame is running, the switch waits, and the settling count starts again once the block is idle.
- R3: Loaded words are sent little-endian: frame data byte 4k+j is bits 8j+7:8j of the k-th word pushed, for j from 0 to 3.
- R4: A word push is ignored while role_rd is 0, and also once 32 words are held.
- R5: A page command (cmd_code 0x10) accepted with 32 words held in program role sends one frame. The frame holds opcode 0x02, then cmd_addr as three bytes with the most significant byte first, then the 128 buffered bytes. Bits go MSB first, one bit per two clocks: flash_sck is low for the first clock and high for the second, and flash_mosi is stable across both.
- R6: busy rises on the clock edge that accepts a command. It stays high for exactly 16 clocks per frame byte (2112 for a page, 80 for a single byte). flash_cs_n is low exactly while busy is high.
- R7: A page command given in prefetch role, or with fewer than 32 words held, sends nothing. It sets page_err, which stays set until reset.
- R8: The word count returns to zero when a page frame completes and when role_rd changes value. A later page command without a fresh load of 32 words is therefore refused.
- R9: A single-byte command (cmd_code 0x90) is accepted in either role. It sends opcode 0x02, the three address bytes and then wr_byte.
- R10: A command that arrives while busy is 1 is ignored, and so is any cmd_code other than 0x10 and 0x90.
- R11: A page command and a push in the same cycle are judged on the word count before that push. With 31 words held, the command is refused and the push is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_set | input | 1 | Write strobe for the buffer-role bit |
| role_val | input | 1 | Requested role: 0 prefetch, 1 program |
| role_rd | output | 1 | Role currently in effect |
| push | input | 1 | Word push strobe |
| push_data | input | 32 | Word to load, little-endian bytes |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (0x10 page, 0x90 single byte) |
| cmd_addr | input | 24 | Flash address captured at command start |
| wr_byte | input | 8 | Byte for single-byte programming |
| page_err | output | 1 | Sticky refused-page-command flag |
| busy | output | 1 | Command in progress |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock |
| flash_mosi | output | 1 | Flash serial data out |

## Verification
Two pairs of events can fall in the same cycle. A word push can coincide with a page command. A role write can coincide with a frame that is still running or with the end of the settling count. The bench provokes the first by pushing word 32 on the same clock as a page command. It judges the result through page_err and through the contents of the next page frame. It provokes the second by requesting prefetch role in the middle of a page frame, and a behavioural model, updated on every clock, says when role_rd must flip. The same model predicts busy and the expected flash frames, which a bench-side receiver decodes from the serial pins.

// File: rtl/nor_pp_wbuf_pkg.sv
package nor_pp_wbuf_pkg;
  typedef enum logic {
    FRAME_BYTE = 1'b0,
    FRAME_PAGE = 1'b1
  } frame_kind_e;

  typedef enum logic {
    ROLE_PREFETCH = 1'b0,
    ROLE_PROGRAM  = 1'b1
  } buf_role_e;
endpackage

// File: rtl/nor_pp_role_ctl.sv
module nor_pp_role_ctl
  import nor_pp_wbuf_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_en,
  input  logic      set_val,
  input  logic      hold,
  output buf_role_e role_q,
  output logic      flip
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  buf_role_e        req_q, req_d, role_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    req_d  = set_en ? buf_role_e'(set_val) : req_q;
    role_d = role_q;
    cnt_d  = '0;
    flip   = 1'b0;
    if ((req_q != role_q) && !hold) begin
      if (cnt_q == CNT_LAST) begin
        role_d = req_q;
        flip   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= ROLE_PREFETCH;
      role_q <= ROLE_PREFETCH;
      cnt_q  <= '0;
    end else begin
      req_q  <= req_d;
      role_q <= role_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/nor_pp_word_store.sv
module nor_pp_word_store #(
  parameter int WORDS  = 32,
  parameter int WORD_W = 32,
  localparam int LANES  = WORD_W / 8,
  localparam int LANE_W = $clog2(LANES),
  localparam int BIDX_W = $clog2(WORDS * LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              allow,
  input  logic              clear,
  output logic              full,
  input  logic [BIDX_W-1:0] rd_idx,
  output logic [7:0]        rd_byte
);
  localparam int PTR_W = $clog2(WORDS + 1);
  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(WORDS);

  logic [PTR_W-1:0]             ptr_q, ptr_d;
  logic                         wr_en;
  logic [WORDS-1:0][WORD_W-1:0] words;
  logic [BIDX_W-LANE_W-1:0]     word_sel;
  logic [LANE_W-1:0]            lane_sel;
  logic [WORD_W-1:0]            sel_word;

  assign full  = (ptr_q == PTR_FULL);
  assign wr_en = push && allow && !full;

  always_comb begin
    ptr_d = ptr_q;
    if (clear) begin
      ptr_d = '0;
    end else if (wr_en) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              word_en;
    assign word_en = wr_en && (ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (word_en) begin
        word_q <= push_data;
      end
    end
    assign words[g] = word_q;
  end

  assign word_sel = rd_idx[BIDX_W-1:LANE_W];
  assign lane_sel = rd_idx[LANE_W-1:0];
  assign sel_word = words[word_sel];
  assign rd_byte  = sel_word[8*lane_sel +: 8];
endmodule

// File: rtl/nor_pp_spi_seq.sv
module nor_pp_spi_seq
  import nor_pp_wbuf_pkg::*;
#(
  parameter int          BUF_BYTES  = 128,
  parameter int          ADDR_BYTES = 3,
  parameter logic [7:0]  PROG_OP    = 8'h02,
  localparam int BIDX_W = $clog2(BUF_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  frame_kind_e             start_kind,
  input  logic [8*ADDR_BYTES-1:0] start_addr,
  input  logic [7:0]              start_byte,
  input  logic [7:0]              page_byte,
  output logic [BIDX_W-1:0]       page_idx,
  output logic                    busy,
  output logic                    page_done,
  output logic                    cs_n,
  output logic                    sck,
  output logic                    mosi
);
  localparam int HDR     = 1 + ADDR_BYTES;
  localparam int MAXBITS = 8 * (HDR + BUF_BYTES);
  localparam int BIT_W   = $clog2(MAXBITS);
  localparam int FB_W    = BIT_W - 3;
  localparam logic [BIT_W-1:0] LAST_PAGE = BIT_W'(MAXBITS - 1);
  localparam logic [BIT_W-1:0] LAST_ONE  = BIT_W'(8 * (HDR + 1) - 1);

  logic                    busy_q, busy_d;
  logic                    phase_q, phase_d;
  logic [BIT_W-1:0]        bit_q, bit_d;
  frame_kind_e             kind_q, kind_d;
  logic [8*ADDR_BYTES-1:0] addr_q, addr_d;
  logic [7:0]              byte_q, byte_d;
  logic [BIT_W-1:0]        last_bit;
  logic                    last;
  logic [FB_W-1:0]         fbyte;
  logic [7:0]              cur_byte;

  assign last_bit  = (kind_q == FRAME_PAGE) ? LAST_PAGE : LAST_ONE;
  assign last      = busy_q && phase_q && (bit_q == last_bit);
  assign page_done = last && (kind_q == FRAME_PAGE);
  assign fbyte     = bit_q[BIT_W-1:3];
  assign page_idx  = BIDX_W'(fbyte - FB_W'(HDR));

  always_comb begin
    if (fbyte == '0) begin
      cur_byte = PROG_OP;
    end else if (kind_q == FRAME_PAGE) begin
      cur_byte = page_byte;
    end else begin
      cur_byte = byte_q;
    end
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (fbyte == FB_W'(k + 1)) begin
        cur_byte = addr_q[8*(ADDR_BYTES-1-k) +: 8];
      end
    end
  end

  assign mosi = busy_q && cur_byte[~bit_q[2:0]];
  assign sck  = busy_q && phase_q;
  assign cs_n = !busy_q;
  assign busy = busy_q;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    byte_d  = byte_q;
    if (start && !busy_q) begin
      busy_d  = 1'b1;
      phase_d = 1'b0;
      bit_d   = '0;
      kind_d  = start_kind;
      addr_d  = start_addr;
      byte_d  = start_byte;
    end else if (busy_q) begin
      phase_d = !phase_q;
      if (phase_q) begin
        if (last) begin
          busy_d = 1'b0;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      bit_q   <= '0;
      kind_q  <= FRAME_BYTE;
      addr_q  <= '0;
      byte_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      byte_q  <= byte_d;
    end
  end
endmodule

// File: rtl/nor_pp_wbuf.sv
module nor_pp_wbuf
  import nor_pp_wbuf_pkg::*;
#(
  parameter int         BUF_BYTES  = 128,
  parameter int         WORD_W     = 32,
  parameter int         ADDR_BYTES = 3,
  parameter int         SETTLE_CYC = 4,
  parameter logic [7:0] PROG_OP    = 8'h02,
  parameter logic [7:0] CMD_PAGE   = 8'h10,
  parameter logic [7:0] CMD_BYTE   = 8'h90
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    role_set,
  input  logic                    role_val,
  output logic                    role_rd,
  input  logic                    push,
  input  logic [WORD_W-1:0]       push_data,
  input  logic                    cmd_valid,
  input  logic [7:0]              cmd_code,
  input  logic [8*ADDR_BYTES-1:0] cmd_addr,
  input  logic [7:0]              wr_byte,
  output logic                    page_err,
  output logic                    busy,
  output logic                    flash_cs_n,
  output logic                    flash_sck,
  output logic                    flash_mosi
);
  localparam int WORDS  = BUF_BYTES / (WORD_W / 8);
  localparam int BIDX_W = $clog2(BUF_BYTES);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  buf_role_e         role;
  logic              role_flip;
  logic              full;
  logic              start_page, start_byte, refuse, start;
  logic              page_done;
  logic              err_q, err_d;
  logic [BIDX_W-1:0] page_idx;
  logic [7:0]        page_byte;
  frame_kind_e       start_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign start_page = cmd_valid && !busy && (cmd_code == CMD_PAGE)
                      && (role == ROLE_PROGRAM) && full;
  assign refuse     = cmd_valid && !busy && (cmd_code == CMD_PAGE)
                      && !((role == ROLE_PROGRAM) && full);
  assign start_byte = cmd_valid && !busy && (cmd_code == CMD_BYTE);
  assign start      = start_page || start_byte;
  assign start_kind = start_page ? FRAME_PAGE : FRAME_BYTE;

  assign err_d = err_q || refuse;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end
  assign page_err = err_q;

  nor_pp_role_ctl #(
    .SETTLE_CYC (SETTLE_CYC)
  ) i_role (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_en  (role_set),
    .set_val (role_val),
    .hold    (busy || start),
    .role_q  (role),
    .flip    (role_flip)
  );
  assign role_rd = (role == ROLE_PROGRAM);

  nor_pp_word_store #(
    .WORDS  (WORDS),
    .WORD_W (WORD_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (push),
    .push_data (push_data),
    .allow     (role == ROLE_PROGRAM),
    .clear     (role_flip || page_done),
    .full      (full),
    .rd_idx    (page_idx),
    .rd_byte   (page_byte)
  );

  nor_pp_spi_seq #(
    .BUF_BYTES  (BUF_BYTES),
    .ADDR_BYTES (ADDR_BYTES),
    .PROG_OP    (PROG_OP)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .start_kind (start_kind),
    .start_addr (cmd_addr),
    .start_byte (wr_byte),
    .page_byte  (page_byte),
    .page_idx   (page_idx),
    .busy       (busy),
    .page_done  (page_done),
    .cs_n       (flash_cs_n),
    .sck        (flash_sck),
    .mosi       (flash_mosi)
  );
endmodule

// File: rtl/nor_pp_wbuf_chk.sv
module nor_pp_wbuf_chk #(
  parameter logic [7:0] CMD_PAGE = 8'h10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       role_rd,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic       page_err,
  input logic       busy,
  input logic       flash_cs_n,
  input logic       flash_sck
);
  // R6
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_cs_n) |-> $past(cmd_valid));

  // R5
  sck_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_sck |=> !flash_sck);

  // R5
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_sck |-> !flash_cs_n);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> $past(cmd_valid && (cmd_code == CMD_PAGE)));

  // R2
  role_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(role_rd) |-> (!busy && !$past(busy)));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
endmodule

bind nor_pp_wbuf nor_pp_wbuf_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .role_rd    (role_rd),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .page_err   (page_err),
  .busy       (busy),
  .flash_cs_n (flash_cs_n),
  .flash_sck  (flash_sck)
);

// File: tb/test_nor_pp_wbuf.sv
module test_nor_pp_wbuf;
  localparam int SETTLE = 4;
  localparam int PAGE_CYC = 2 * 8 * (4 + 128);
  localparam int BYTE_CYC = 2 * 8 * (4 + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        role_set = 1'b0, role_val = 1'b0;
  logic        push = 1'b0;
  logic [31:0] push_data = '0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [23:0] cmd_addr = '0;
  logic [7:0]  wr_byte = '0;
  logic        role_rd, page_err, busy, flash_cs_n, flash_sck, flash_mosi;

  always #5 clk = ~clk;

  nor_pp_wbuf i_nor_pp_wbuf (
    .clk(clk), .rst_n(rst_n), .role_set(role_set), .role_val(role_val),
    .role_rd(role_rd), .push(push), .push_data(push_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .wr_byte(wr_byte), .page_err(page_err), .busy(busy),
    .flash_cs_n(flash_cs_n), .flash_sck(flash_sck), .flash_mosi(flash_mosi)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_busy, m_cnt, m_ptr, m_frames;
  bit          m_page, m_eff, m_req, m_err;
  logic [31:0] m_words [32];
  byte unsigned exp_q[$];

  task automatic build_frame(input logic [23:0] a, input bit page, input logic [7:0] b);
    exp_q.delete();
    exp_q.push_back(8'h02);
    exp_q.push_back(a[23:16]);
    exp_q.push_back(a[15:8]);
    exp_q.push_back(a[7:0]);
    if (page) begin
      for (int i = 0; i < 128; i++) exp_q.push_back(m_words[i/4][8*(i%4) +: 8]);
    end else begin
      exp_q.push_back(b);
    end
    m_frames++;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_ptr = 0; m_page = 0;
      m_eff = 0; m_req = 0; m_err = 0;
    end else begin
      bit b_old, acc, req_old;
      b_old = (m_busy > 0);
      acc = 0;
      if (cmd_valid && !b_old) begin
        if (cmd_code == 8'h90) begin
          acc = 1; m_page = 0; m_busy = BYTE_CYC;
          build_frame(cmd_addr, 0, wr_byte);
        end else if (cmd_code == 8'h10) begin
          if (m_eff && m_ptr == 32) begin
            acc = 1; m_page = 1; m_busy = PAGE_CYC;
            build_frame(cmd_addr, 1, 8'h00);
          end else begin
            m_err = 1;
          end
        end
      end
      if (push && m_eff && m_ptr < 32) begin
        m_words[m_ptr] = push_data;
        m_ptr++;
      end
      if (b_old) begin
        m_busy--;
        if (m_busy == 0 && m_page) m_ptr = 0;
      end
      req_old = m_req;
      if (role_set) m_req = role_val;
      if (req_old != m_eff && !b_old && !acc) begin
        if (m_cnt == SETTLE - 1) begin
          m_eff = req_old; m_cnt = 0; m_ptr = 0;
        end else begin
          m_cnt++;
        end
      end else begin
        m_cnt = 0;
      end
    end
  end

  // ---------------- receiver and per-clock comparison ----------------
  int          nbits = 0, got_frames = 0, cyc = 0;
  logic [7:0]  cur = '0;
  byte unsigned got_q[$];

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      chk(busy == (m_busy > 0), "R6", "busy", busy, m_busy > 0);
      chk(flash_cs_n == (m_busy == 0), "R6", "cs_n", flash_cs_n, m_busy == 0);
      chk(role_rd == m_eff, "R2", "role_rd", role_rd, m_eff);
      chk(page_err == m_err, "R7", "page_err", page_err, m_err);
      if (!flash_cs_n) begin
        if (flash_sck) begin
          cur = {cur[6:0], flash_mosi};
          nbits++;
          if (nbits % 8 == 0) got_q.push_back(cur);
        end
      end else if (nbits > 0) begin
        int bad;
        int first;
        bad = 0; first = -1;
        got_frames++;
        chk(got_q.size() == exp_q.size(), tag, "frame length", got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
          if (got_q[i] != exp_q[i]) begin bad++; if (first < 0) first = i; end
        if (first >= 0)
          chk(0, tag, $sformatf("frame byte %0d", first), got_q[first], exp_q[first]);
        else
          chk(1, tag, "frame bytes", 0, 0);
        got_q.delete();
        nbits = 0;
      end
    end else begin
      nbits = 0; got_q.delete();
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && flash_cs_n == 1 && flash_sck == 0, "R1", "frame pins in reset",
        {busy, flash_cs_n, flash_sck}, 3'b010);
    chk(role_rd == 0 && page_err == 0, "R1", "role/err in reset", {role_rd, page_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    got_frames = 0; m_frames = 0;
  endtask

  task automatic set_role(input logic v);
    role_set = 1'b1; role_val = v;
    @(negedge clk);
    role_set = 1'b0;
  endtask

  task automatic do_push(input logic [31:0] d);
    push = 1'b1; push_data = d;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic do_cmd(input logic [7:0] c, input logic [23:0] a, input logic [7:0] b);
    cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; wr_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    do @(negedge clk); while (busy);
    repeat (SETTLE + 3) @(negedge clk);
  endtask

  function automatic logic [31:0] wval(input int seed, input int i);
    return 32'h1357_9BDF ^ (32'h0102_0304 * (i + 1)) ^ (seed << 24);
  endfunction

  task automatic fill(input int seed, input int n);
    for (int i = 0; i < n; i++) do_push(wval(seed, i));
  endtask

  task automatic frames_chk(input string rq);
    chk(got_frames == m_frames, rq, "frame count", got_frames, m_frames);
  endtask

  initial begin
    do_reset();
    chk(busy == 0 && flash_cs_n == 1 && role_rd == 0 && page_err == 0, "R1",
        "after reset", {busy, flash_cs_n, role_rd, page_err}, 4'b0100);

    tag = "R9";
    do_cmd(8'h90, 24'h0A0B0C, 8'h5A);
    settle();
    frames_chk("R9");
    tag = "R7";
    do_cmd(8'h10, 24'h000100, 8'h00);
    settle();
    chk(page_err == 1, "R7", "refused in prefetch role", page_err, 1);
    frames_chk("R7");

    do_reset();
    tag = "R4";
    fill(7, 3);
    set_role(1'b1);
    settle();
    fill(1, 31);
    do_cmd(8'h10, 24'h123400, 8'h00);
    settle();
    chk(page_err == 1, "R7", "refused with 31 words", page_err, 1);
    frames_chk("R4");
    do_push(wval(1, 31));
    do_push(32'hDEAD_BEEF);
    do_push(32'hFEED_F00D);
    tag = "R5";
    do_cmd(8'h10, 24'hABCDEF, 8'h00);
    repeat (100) @(negedge clk);
    do_cmd(8'h90, 24'h111111, 8'h22);
    do_cmd(8'h10, 24'h222222, 8'h00);
    set_role(1'b0);
    settle();
    frames_chk("R10");
    chk(role_rd == 0, "R2", "switch after frame", role_rd, 0);
    tag = "R10";
    do_cmd(8'h55, 24'h333333, 8'h44);
    settle();
    frames_chk("R10");

    do_reset();
    tag = "R3";
    set_role(1'b1);
    settle();
    fill(3, 32);
    do_cmd(8'h10, 24'h00FF00, 8'h00);
    settle();
    tag = "R8";
    do_cmd(8'h10, 24'h00FF00, 8'h00);
    settle();
    chk(page_err == 1, "R8", "count cleared after page", page_err, 1);
    frames_chk("R8");

    do_reset();
    set_role(1'b1);
    settle();
    fill(4, 32);
    set_role(1'b0);
    settle();
    set_role(1'b1);
    settle();
    do_cmd(8'h10, 24'h040404, 8'h00);
    settle();
    chk(page_err == 1, "R8", "count cleared by role change", page_err, 1);
    frames_chk("R8");

    do_reset();
    tag = "R11";
    set_role(1'b1);
    settle();
    fill(5, 31);
    push = 1'b1; push_data = 32'hC0FF_EE11;
    cmd_valid = 1'b1; cmd_code = 8'h10; cmd_addr = 24'h555555;
    @(negedge clk);
    push = 1'b0; cmd_valid = 1'b0;
    @(negedge clk);
    chk(page_err == 1, "R11", "same-cycle command refused", page_err, 1);
    do_cmd(8'h10, 24'h565656, 8'h00);
    settle();
    frames_chk("R11");
    tag = "R9";
    do_cmd(8'h90, 24'hFEDCBA, 8'hC3);
    settle();
    frames_chk("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule